// File: doc/BRIEF.md
# Partitioned SIMD Saturating Adder

This block adds or subtracts two packed operand words whose carry path can be split at run time into independent lanes. One select picks the lane width (one full-width lane, or lanes of half, quarter or eighth width). No carry or borrow ever passes from one lane into the next. A second select treats every lane as signed or unsigned. A third select chooses between modular wraparound and clamping. Subtraction is done by adding the bitwise complement of the second operand with a carry of one into the lowest bit of every lane.

Each lane finds its own overflow. In wrap mode the lane keeps its modular result and still raises its flag. In clamp mode an overflowing lane is replaced by the limit of its range in the direction it overflowed. The adder path is combinational. A parameter adds one registered output stage, and that stage is on by default. Typical uses are packed pixel and audio sample arithmetic, where clipping is wanted in place of wraparound.

Top module: `simd_sat_adder`

## Requirements
- R1: `lane_sel_i` encodes the lane width: 2'b00 = 8 bits, 2'b01 = 16 bits, 2'b10 = 32 bits, 2'b11 = 64 bits. Lane j covers bits [j*w +: w], and no carry or borrow crosses from one lane into the next.
- R2: When `sub_i`=0 and `sat_i`=0, each lane of `sum_o` is (a + b) mod 2^w.
- R3: When `sub_i`=1 and `sat_i`=0, each lane of `sum_o` is (a - b) mod 2^w, formed as a + ~b + 1 within the lane.
- R4: For a signed add (`signed_i`=1), a lane overflows only when both operand signs match and the result sign differs from them. Operands of mixed sign never overflow.
- R5: For a signed subtract, a lane overflows only when the operand signs differ and the result sign differs from the sign of a.
- R6: For unsigned lanes (`signed_i`=0), an add flags overflow on a carry out of the lane's top bit, and a subtract flags overflow when a < b (a borrow).
- R7: `ovf_o` bit i belongs to byte i. A lane's flag sits on the bit of its lowest byte, and every other bit of that lane is 0.
- R8: With `sat_i`=1 and signed lanes, an overflowing lane becomes the largest positive value (0x7F..F) when a is non-negative, and the most negative value (0x80..0) when a is negative.
- R9: With `sat_i`=1 and unsigned lanes, an overflowing add gives all ones and an overflowing subtract gives zero.
- R10: Overflow flags are reported in both wrap and clamp modes. In wrap mode a flagged lane still carries its modular result.
- R11: With `OUT_REG`=1, `sum_o` and `ovf_o` appear one clock after the inputs are applied, and a synchronous active-high `rst` clears both to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 64 | First packed operand |
| b_i | input | 64 | Second packed operand |
| lane_sel_i | input | 2 | Lane width select (R1 encoding) |
| signed_i | input | 1 | 1 = signed lanes, 0 = unsigned |
| sat_i | input | 1 | 1 = clamp on overflow, 0 = wrap |
| sub_i | input | 1 | 1 = a - b, 0 = a + b |
| sum_o | output | 64 | Packed lane results |
| ovf_o | output | 8 | Per-lane overflow flags, one bit per byte position |

## Verification
The assertions assume that all operand and control inputs are known and do not change within a clock period. They also assume that the lane select and the mode selects apply to the same cycle as the operands, because the properties compare the combinational result against the inputs sampled at the same edge. The bench keeps to these assumptions. It drives every input only on the falling edge and holds it for a full cycle. It keeps reset high for the first edges, so no property sees values from before reset. Its stimulus covers all four lane widths, both sign modes, both overflow modes and both operations. It sets operands at the exact range limits of each width.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

    typedef enum logic [1:0] {
        LANE_8  = 2'b00,
        LANE_16 = 2'b01,
        LANE_32 = 2'b10,
        LANE_64 = 2'b11
    } lane_e;

    typedef struct packed {
        logic  is_signed;
        logic  saturate;
        logic  subtract;
        lane_e lane;
    } ctrl_t;

    // number of byte slices that make up one lane
    function automatic int lane_slices(lane_e l, int n_slices);
        int n;
        n = 1 << int'(l);
        return (n > n_slices) ? n_slices : n;
    endfunction

    function automatic logic is_lane_low(int k, lane_e l, int n_slices);
        return (k % lane_slices(l, n_slices)) == 0;
    endfunction

    function automatic logic is_lane_top(int k, lane_e l, int n_slices);
        int n;
        n = lane_slices(l, n_slices);
        return (k % n) == (n - 1);
    endfunction

    function automatic int lane_top(int k, lane_e l, int n_slices);
        int n;
        n = lane_slices(l, n_slices);
        return (k / n) * n + n - 1;
    endfunction

    // flag-bit mask of the lane-low positions for a given lane width
    function automatic logic [63:0] low_mask(lane_e l, int n_slices);
        logic [63:0] m;
        m = '0;
        for (int k = 0; k < n_slices; k++) begin
            m[k] = is_lane_low(k, l, n_slices);
        end
        return m;
    endfunction

endpackage

// File: rtl/simd_slice_chain.sv
module simd_slice_chain
    import simd_add_pkg::*;
#(
    parameter int SLICE_W    = 8,
    parameter int NUM_SLICES = 8
) (
    input  logic [SLICE_W*NUM_SLICES-1:0] a_i,
    input  logic [SLICE_W*NUM_SLICES-1:0] b_i,
    input  ctrl_t                         ctrl_i,
    output logic [SLICE_W*NUM_SLICES-1:0] bx_o,
    output logic [SLICE_W*NUM_SLICES-1:0] sum_o,
    output logic [NUM_SLICES-1:0]         cout_o
);
    localparam int DATA_W = SLICE_W * NUM_SLICES;

    // second operand as seen by the adder: complemented for subtract
    assign bx_o = ctrl_i.subtract ? ~b_i : b_i;

    for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
        logic               cin;
        logic               cout;
        logic [SLICE_W-1:0] s;

        if (k == 0) begin : g_first
            assign cin = ctrl_i.subtract;
        end else begin : g_rest
            // a lane boundary cuts the chain and reinjects the +1 of negation
            assign cin = is_lane_low(k, ctrl_i.lane, NUM_SLICES)
                         ? ctrl_i.subtract : g_slice[k-1].cout;
        end

        assign {cout, s} = {1'b0, a_i[k*SLICE_W +: SLICE_W]}
                         + {1'b0, bx_o[k*SLICE_W +: SLICE_W]}
                         + {{SLICE_W{1'b0}}, cin};

        assign sum_o[k*SLICE_W +: SLICE_W] = s;
        assign cout_o[k]                   = cout;
    end

    if (DATA_W % 64 != 0 && DATA_W > 64) begin : g_width_note
        // widths above 64 must be whole multiples of the widest lane
        initial $display("simd_slice_chain: unusual width %0d", DATA_W);
    end

endmodule

// File: rtl/simd_lane_flags.sv
module simd_lane_flags
    import simd_add_pkg::*;
#(
    parameter int SLICE_W    = 8,
    parameter int NUM_SLICES = 8
) (
    input  logic [SLICE_W*NUM_SLICES-1:0] a_i,
    input  logic [SLICE_W*NUM_SLICES-1:0] bx_i,
    input  logic [SLICE_W*NUM_SLICES-1:0] sum_i,
    input  logic [NUM_SLICES-1:0]         cout_i,
    input  ctrl_t                         ctrl_i,
    output logic [NUM_SLICES-1:0]         slice_ovf_o,
    output logic [NUM_SLICES-1:0]         slice_neg_o,
    output logic [NUM_SLICES-1:0]         lane_ovf_o
);
    logic [NUM_SLICES-1:0] top_ovf;
    logic [NUM_SLICES-1:0] top_neg;

    // overflow of each slice assuming it were the top slice of its lane
    always_comb begin
        for (int k = 0; k < NUM_SLICES; k++) begin
            logic a_msb;
            logic b_msb;
            logic s_msb;
            a_msb = a_i[k*SLICE_W + SLICE_W - 1];
            b_msb = bx_i[k*SLICE_W + SLICE_W - 1];
            s_msb = sum_i[k*SLICE_W + SLICE_W - 1];
            if (ctrl_i.is_signed) begin
                // bx is already negated for subtract, so one rule serves both
                top_ovf[k] = (a_msb == b_msb) && (s_msb != a_msb);
            end else begin
                top_ovf[k] = ctrl_i.subtract ? ~cout_i[k] : cout_i[k];
            end
            top_neg[k] = a_msb;
        end
    end

    // spread each lane's top-slice result over the whole lane
    always_comb begin
        for (int k = 0; k < NUM_SLICES; k++) begin
            int t;
            t = lane_top(k, ctrl_i.lane, NUM_SLICES);
            slice_ovf_o[k] = top_ovf[t];
            slice_neg_o[k] = top_neg[t];
            lane_ovf_o[k]  = top_ovf[t] && is_lane_low(k, ctrl_i.lane, NUM_SLICES);
        end
    end

endmodule

// File: rtl/simd_lane_clamp.sv
module simd_lane_clamp
    import simd_add_pkg::*;
#(
    parameter int SLICE_W    = 8,
    parameter int NUM_SLICES = 8
) (
    input  logic [SLICE_W*NUM_SLICES-1:0] sum_i,
    input  logic [NUM_SLICES-1:0]         slice_ovf_i,
    input  logic [NUM_SLICES-1:0]         slice_neg_i,
    input  ctrl_t                         ctrl_i,
    output logic [SLICE_W*NUM_SLICES-1:0] res_o
);
    always_comb begin
        for (int k = 0; k < NUM_SLICES; k++) begin
            logic               top;
            logic               neg;
            logic [SLICE_W-1:0] limit;
            top = is_lane_top(k, ctrl_i.lane, NUM_SLICES);
            neg = slice_neg_i[k];
            if (ctrl_i.is_signed) begin
                // sign bit lives only in the top slice of the lane
                limit = top ? {neg, {(SLICE_W-1){~neg}}} : {SLICE_W{~neg}};
            end else begin
                limit = {SLICE_W{~ctrl_i.subtract}};
            end
            res_o[k*SLICE_W +: SLICE_W] = (ctrl_i.saturate && slice_ovf_i[k])
                                          ? limit : sum_i[k*SLICE_W +: SLICE_W];
        end
    end

endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
    import simd_add_pkg::*;
#(
    parameter int SLICE_W    = 8,
    parameter int NUM_SLICES = 8,
    parameter bit OUT_REG    = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [SLICE_W*NUM_SLICES-1:0] a_i,
    input  logic [SLICE_W*NUM_SLICES-1:0] b_i,
    input  logic [1:0]                    lane_sel_i,
    input  logic                          signed_i,
    input  logic                          sat_i,
    input  logic                          sub_i,
    output logic [SLICE_W*NUM_SLICES-1:0] sum_o,
    output logic [NUM_SLICES-1:0]         ovf_o
);
    localparam int DATA_W = SLICE_W * NUM_SLICES;
    localparam int MSB    = DATA_W - 1;

    ctrl_t                 ctrl;
    logic [DATA_W-1:0]     bx;
    logic [DATA_W-1:0]     raw_sum;
    logic [NUM_SLICES-1:0] slice_cout;
    logic [NUM_SLICES-1:0] slice_ovf;
    logic [NUM_SLICES-1:0] slice_neg;
    logic [NUM_SLICES-1:0] ovf_d;
    logic [DATA_W-1:0]     res_d;

    always_comb begin
        ctrl.is_signed = signed_i;
        ctrl.saturate  = sat_i;
        ctrl.subtract  = sub_i;
        ctrl.lane      = lane_e'(lane_sel_i);
    end

    simd_slice_chain #(.SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) u_chain (
        .a_i    (a_i),
        .b_i    (b_i),
        .ctrl_i (ctrl),
        .bx_o   (bx),
        .sum_o  (raw_sum),
        .cout_o (slice_cout)
    );

    simd_lane_flags #(.SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) u_flags (
        .a_i         (a_i),
        .bx_i        (bx),
        .sum_i       (raw_sum),
        .cout_i      (slice_cout),
        .ctrl_i      (ctrl),
        .slice_ovf_o (slice_ovf),
        .slice_neg_o (slice_neg),
        .lane_ovf_o  (ovf_d)
    );

    simd_lane_clamp #(.SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) u_clamp (
        .sum_i       (raw_sum),
        .slice_ovf_i (slice_ovf),
        .slice_neg_i (slice_neg),
        .ctrl_i      (ctrl),
        .res_o       (res_d)
    );

    if (OUT_REG) begin : g_out_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                sum_o <= '0;
                ovf_o <= '0;
            end else begin
                sum_o <= res_d;
                ovf_o <= ovf_d;
            end
        end
    end else begin : g_out_comb
        assign sum_o = res_d;
        assign ovf_o = ovf_d;
    end

    // R4: mixed-sign signed add on the full-width lane never flags
    p_mixed_add_r4: assert property (@(posedge clk) disable iff (rst)
        (signed_i && !sub_i && lane_sel_i == 2'b11 && (a_i[MSB] != b_i[MSB]))
        |-> !ovf_d[0]);

    // R5: same-sign signed subtract on the full-width lane never flags
    p_same_sub_r5: assert property (@(posedge clk) disable iff (rst)
        (signed_i && sub_i && lane_sel_i == 2'b11 && (a_i[MSB] == b_i[MSB]))
        |-> !ovf_d[0]);

    // R7: flags only appear on lane-low byte positions
    p_flag_layout_r7: assert property (@(posedge clk) disable iff (rst)
        (ovf_d & ~low_mask(lane_e'(lane_sel_i), NUM_SLICES)[NUM_SLICES-1:0]) == '0);

    // R8: full-width signed clamp goes to the limit on the side of a
    p_signed_clamp_r8: assert property (@(posedge clk) disable iff (rst)
        (sat_i && signed_i && lane_sel_i == 2'b11 && ovf_d[0])
        |-> res_d == (a_i[MSB] ? {1'b1, {(DATA_W-1){1'b0}}}
                               : {1'b0, {(DATA_W-1){1'b1}}}));

    // R9: unsigned clamped add in the lowest byte lane gives all ones
    p_unsigned_clamp_r9: assert property (@(posedge clk) disable iff (rst)
        (sat_i && !signed_i && !sub_i && lane_sel_i == 2'b00 && ovf_d[0])
        |-> res_d[SLICE_W-1:0] == {SLICE_W{1'b1}});

    // R2: full-width wrap add equals the plain modular sum
    p_wrap_add_r2: assert property (@(posedge clk) disable iff (rst)
        (!sat_i && !sub_i && lane_sel_i == 2'b11)
        |-> res_d == a_i + b_i);

endmodule

// File: tb/simd_sat_adder_bench.sv
module simd_sat_adder_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  lane;
        logic        sgn;
        logic        sat;
        logic        sub;
        logic [63:0] a;
        logic [63:0] b;
    } stim_t;

    localparam int N_STIM = 14;
    localparam stim_t STIM [N_STIM] = '{
        '{2'b00, 1'b0, 1'b0, 1'b0, 64'hFF80_7F01_1234_ABCD, 64'h0180_0101_FEDC_5433},
        '{2'b00, 1'b1, 1'b1, 1'b0, 64'h7F80_7F80_4040_C0C0, 64'h01FF_7F80_4040_C0C0},
        '{2'b00, 1'b0, 1'b1, 1'b1, 64'h0010_FF00_8080_0102, 64'h0120_0001_7F81_0201},
        '{2'b00, 1'b1, 1'b1, 1'b1, 64'h807F_0080_7F00_8001, 64'h0180_8001_FF7F_7F02},
        '{2'b01, 1'b0, 1'b1, 1'b0, 64'hFFFF_8000_0001_7FFF, 64'h0001_8000_FFFF_0001},
        '{2'b01, 1'b1, 1'b1, 1'b0, 64'h7FFF_8000_4000_C000, 64'h0001_FFFF_4000_C000},
        '{2'b01, 1'b1, 1'b0, 1'b1, 64'h8000_7FFF_0000_1234, 64'h0001_FFFF_8000_1234},
        '{2'b10, 1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF_8000_0000, 64'h0000_0001_8000_0000},
        '{2'b10, 1'b1, 1'b1, 1'b1, 64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF},
        '{2'b10, 1'b0, 1'b1, 1'b1, 64'h0000_0001_0000_0002, 64'h0000_0002_0000_0001},
        '{2'b11, 1'b1, 1'b1, 1'b0, 64'h7FFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0010},
        '{2'b11, 1'b1, 1'b1, 1'b0, 64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFE},
        '{2'b11, 1'b0, 1'b1, 1'b1, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0004},
        '{2'b11, 1'b0, 1'b0, 1'b0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] a_i = '0;
    logic [63:0] b_i = '0;
    logic [1:0]  lane_sel_i = '0;
    logic        signed_i = 1'b0;
    logic        sat_i = 1'b0;
    logic        sub_i = 1'b0;
    logic [63:0] sum_o;
    logic [7:0]  ovf_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_sat_adder u_simd_sat_adder (
        .clk        (clk),
        .rst        (rst),
        .a_i        (a_i),
        .b_i        (b_i),
        .lane_sel_i (lane_sel_i),
        .signed_i   (signed_i),
        .sat_i      (sat_i),
        .sub_i      (sub_i),
        .sum_o      (sum_o),
        .ovf_o      (ovf_o)
    );

    // per-lane reference with plain integer arithmetic at the lane width
    function automatic logic [71:0] ref_calc(stim_t s);
        int          w;
        int          nl;
        logic [63:0] r;
        logic [7:0]  f;
        w  = 8 << s.lane;
        nl = 64 / w;
        r  = '0;
        f  = '0;
        for (int l = 0; l < nl; l++) begin
            logic [65:0]        umax;
            logic [65:0]        ua;
            logic [65:0]        ub;
            logic [65:0]        ur;
            logic [65:0]        lv;
            logic signed [65:0] sa;
            logic signed [65:0] sb;
            logic signed [65:0] sr;
            logic signed [65:0] smax;
            logic signed [65:0] smin;
            logic               o;
            umax = (66'd1 << w) - 66'd1;
            ua   = ({2'b00, s.a} >> (l*w)) & umax;
            ub   = ({2'b00, s.b} >> (l*w)) & umax;
            sa   = ua[w-1] ? ($signed(ua) - $signed(66'd1 << w)) : $signed(ua);
            sb   = ub[w-1] ? ($signed(ub) - $signed(66'd1 << w)) : $signed(ub);
            smax = $signed(66'd1 << (w-1)) - 66'sd1;
            smin = -$signed(66'd1 << (w-1));
            if (s.sgn) begin
                sr = s.sub ? (sa - sb) : (sa + sb);
                o  = (sr > smax) || (sr < smin);
                lv = (s.sat && o) ? ((sr > smax) ? $unsigned(smax) : $unsigned(smin))
                                  : $unsigned(sr);
            end else begin
                ur = s.sub ? (ua - ub) : (ua + ub);
                o  = s.sub ? (ua < ub) : (ur > umax);
                lv = (s.sat && o) ? (s.sub ? 66'd0 : umax) : ur;
            end
            lv = lv & umax;
            r  = r | (lv[63:0] << (l*w));
            f[(l*w)/8] = o;
        end
        return {f, r};
    endfunction

    task automatic apply(stim_t s);
        @(negedge clk);
        lane_sel_i = s.lane;
        signed_i   = s.sgn;
        sat_i      = s.sat;
        sub_i      = s.sub;
        a_i        = s.a;
        b_i        = s.b;
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, logic [63:0] exp_sum, logic [7:0] exp_ovf);
        total++;
        if (sum_o !== exp_sum || ovf_o !== exp_ovf) begin
            bad++;
            $display("FAIL %s: sum=%h ovf=%b expected sum=%h ovf=%b",
                     tag, sum_o, ovf_o, exp_sum, exp_ovf);
        end
    endtask

    function automatic stim_t mk(logic [1:0] lane, logic sgn, logic sat, logic sub,
                                 logic [63:0] a, logic [63:0] b);
        stim_t s;
        s.lane = lane; s.sgn = sgn; s.sat = sat; s.sub = sub; s.a = a; s.b = b;
        return s;
    endfunction

    initial begin
        logic [71:0] e;
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset state", 64'h0, 8'h00);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < N_STIM; i++) begin
            apply(STIM[i]);
            e = ref_calc(STIM[i]);
            // covers R1 R2 R3 R4 R5 R6 R8 R9 R10 across the table
            check("R1 R2 R3 R4 R5 R6 R8 R9 R10 lane reference", e[63:0], e[71:64]);
        end

        // R1: carry stops at an 8-bit boundary
        apply(mk(2'b00, 1'b0, 1'b0, 1'b0, 64'h0000_0000_0000_00FF, 64'h1));
        check("R1 byte lane carry cut", 64'h0, 8'h01);
        // R1: same operands in a 16-bit lane carry into byte 1
        apply(mk(2'b01, 1'b0, 1'b0, 1'b0, 64'h0000_0000_0000_00FF, 64'h1));
        check("R1 halfword carry passes", 64'h0000_0000_0000_0100, 8'h00);
        // R3 R6: unsigned wrap subtract with borrow
        apply(mk(2'b00, 1'b0, 1'b0, 1'b1, 64'h0, 64'h1));
        check("R3 R6 wrap borrow", 64'h0000_0000_0000_00FF, 8'h01);
        // R8 R7: signed byte clamp positive in byte 3
        apply(mk(2'b00, 1'b1, 1'b1, 1'b0, 64'h7F00_0000, 64'h0100_0000));
        check("R8 R7 signed byte clamp high", 64'h0000_0000_7F00_0000, 8'h08);
        // R8: signed 16-bit clamp negative in lane 1
        apply(mk(2'b01, 1'b1, 1'b1, 1'b0, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_0000));
        check("R8 signed halfword clamp low", 64'h0000_0000_8000_0000, 8'h04);
        // R9 R7: unsigned 32-bit clamp on borrow in upper lane
        apply(mk(2'b10, 1'b0, 1'b1, 1'b1, 64'h0000_0005_0000_0009, 64'h0000_0009_0000_0005));
        check("R9 R7 unsigned word clamp zero", 64'h0000_0000_0000_0004, 8'h10);
        // R5 R10: signed wrap subtract overflows but keeps modular value
        apply(mk(2'b11, 1'b1, 1'b0, 1'b1, 64'h8000_0000_0000_0000, 64'h1));
        check("R5 R10 wrap keeps modular result", 64'h7FFF_FFFF_FFFF_FFFF, 8'h01);
        // R9: unsigned full-width clamp on carry out
        apply(mk(2'b11, 1'b0, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2));
        check("R9 unsigned full clamp ones", 64'hFFFF_FFFF_FFFF_FFFF, 8'h01);
        // R4: mixed-sign signed add never flags
        apply(mk(2'b00, 1'b1, 1'b1, 1'b0, 64'h7F80_7F80_7F80_7F80, 64'h807F_807F_807F_807F));
        check("R4 mixed sign no overflow", 64'hFFFF_FFFF_FFFF_FFFF, 8'h00);

        // R11: reset mid-run clears the registered outputs
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R11 reset clears outputs", 64'h0, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        // R11: one-cycle latency after release
        apply(mk(2'b11, 1'b0, 1'b0, 1'b0, 64'h5, 64'h7));
        check("R11 registered latency", 64'hC, 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule